// File: doc/BRIEF.md
# SHA-256 Message Schedule Sigma0 Update Unit

This unit performs the first half of a SHA-256 message-schedule step on a 128-bit vector of four 32-bit words. It receives the old destination vector X and a second source vector Y. The lane vector is a funnel of the two operands: the low word of Y moves into the top lane, and X drops down by one word. Each lane of that vector goes through the small sigma0 function, and the matching word of X is added to it. Each lane adds on its own, modulo 2^32.

Alongside the data, the unit decodes the 32-bit instruction word that requested the operation. It extracts the destination and source quad-register indices and flags encodings that are malformed or not permitted. The operands, the instruction word and a valid strobe arrive together. One clock later the unit presents the result, the indices, a write-enable for a good operation and an undefined flag for a rejected one. A host pipeline uses it as one execution stage, placed after operand read and before register writeback.

Top module: `sched_sigma0_unit`

## Requirements
- R1: Word e of any 128-bit vector occupies bits [32e+31:32e]. The lane vector T is {Y[31:0], X[127:32]}, so lane 3 of T is Y word 0, and lane e<3 is X word e+1.
- R2: Each T lane t is transformed to (t rotated right 7) XOR (t rotated right 18) XOR (t shifted right logically 3).
- R3: Result word e is the transformed T lane e plus X word e, modulo 2^32, with no carry passing between lanes.
- R4: valid_out is high in the cycle after each cycle with valid_in high, and low after each cycle with valid_in low, so one request gives a single-cycle pulse.
- R5: A size field insn[19:18] other than 2'b10 makes the request undefined.
- R6: A set bit insn[12] (low bit of the destination field insn[15:12]) or insn[0] (low bit of the source field insn[3:0]) makes the request undefined.
- R7: The request is undefined unless insn[31:23]=9'b111100111, insn[21:20]=2'b11, insn[17:16]=2'b10, insn[11:6]=6'b001111 and insn[4]=0.
- R8: The destination register number is {insn[22], insn[15:12]} and the source register number is {insn[5], insn[3:0]}. dst_idx and src_idx are these numbers shifted right by one: {insn[22], insn[15:13]} and {insn[5], insn[3:1]}.
- R9: An undefined request gives undef=1, wr_en=0 and result=0. A good request gives wr_en=1 and undef=0. Both flags are low when valid_out is low.
- R10: A synchronous active-high rst clears valid_out, wr_en, undef and result at the next rising edge, and it overrides a valid_in in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe for insn, x_in, y_in |
| insn | input | 32 | Instruction word to decode |
| x_in | input | 128 | Old destination vector X |
| y_in | input | 128 | Second source vector Y |
| valid_out | output | 1 | Result presented this cycle |
| wr_en | output | 1 | Good request; write result back |
| undef | output | 1 | Rejected request |
| dst_idx | output | 4 | Destination quad-register index |
| src_idx | output | 4 | Source quad-register index |
| result | output | 128 | Updated schedule vector |

## Verification
The decode verdict and the arithmetic are computed in the same cycle from one request, so a rejected encoding always meets live operands. The bench sends bad size fields, odd register fields and corrupted fixed bits with nonzero X and Y. It checks that result is zero, undef is high and wr_en is low, and then that the next good request with the same operands returns the value from the formula. It also raises reset in the same cycle as a request and checks that the reset wins.

// File: rtl/sigma0_pkg.sv
package sigma0_pkg;
    localparam int INSN_W = 32;
    localparam int QIDX_W = 4;

    localparam logic [8:0] OPC_HI   = 9'b111100111;
    localparam logic [1:0] OPC_MID  = 2'b11;
    localparam logic [1:0] OPC_LOW  = 2'b10;
    localparam logic [5:0] OPC_FUNC = 6'b001111;
    localparam logic [1:0] SIZE_32  = 2'b10;

    typedef struct packed {
        logic              undef;
        logic [QIDX_W-1:0] dst;
        logic [QIDX_W-1:0] src;
    } dec_t;
endpackage

// File: rtl/s0_decode.sv
module s0_decode
    import sigma0_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic opc_ok;
    logic size_bad;
    logic reg_odd;

    always_comb begin
        opc_ok   = (insn[31:23] == OPC_HI) && (insn[21:20] == OPC_MID) &&
                   (insn[17:16] == OPC_LOW) && (insn[11:6] == OPC_FUNC) &&
                   (insn[4] == 1'b0);
        size_bad = (insn[19:18] != SIZE_32);
        reg_odd  = insn[12] | insn[0];
        dec.undef = !opc_ok || size_bad || reg_odd;
        // register number {ext, field} halved gives the quad index
        dec.dst = {insn[22], insn[15:13]};
        dec.src = {insn[5], insn[3:1]};
    end
endmodule

// File: rtl/s0_lane.sv
module s0_lane #(
    parameter int LANE_W = 32,
    parameter int ROT_A  = 7,
    parameter int ROT_B  = 18,
    parameter int SHR_C  = 3
) (
    input  logic [LANE_W-1:0] t_i,
    input  logic [LANE_W-1:0] x_i,
    output logic [LANE_W-1:0] sum_o
);
    function automatic logic [LANE_W-1:0] rotr(input logic [LANE_W-1:0] v, input int n);
        return (v >> n) | (v << (LANE_W - n));
    endfunction

    logic [LANE_W-1:0] sig;

    always_comb begin
        sig   = rotr(t_i, ROT_A) ^ rotr(t_i, ROT_B) ^ (t_i >> SHR_C);
        sum_o = sig + x_i;
    end
endmodule

// File: rtl/sched_sigma0_unit.sv
module sched_sigma0_unit
    import sigma0_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    parameter int ROT_A  = 7,
    parameter int ROT_B  = 18,
    parameter int SHR_C  = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_in,
    input  logic [INSN_W-1:0]         insn,
    input  logic [LANE_W*LANES-1:0]   x_in,
    input  logic [LANE_W*LANES-1:0]   y_in,
    output logic                      valid_out,
    output logic                      wr_en,
    output logic                      undef,
    output logic [QIDX_W-1:0]         dst_idx,
    output logic [QIDX_W-1:0]         src_idx,
    output logic [LANE_W*LANES-1:0]   result
);
    localparam int VEC_W = LANE_W * LANES;

    typedef struct packed {
        logic              valid;
        logic              wr_en;
        logic              undef;
        logic [QIDX_W-1:0] dst;
        logic [QIDX_W-1:0] src;
        logic [VEC_W-1:0]  result;
    } stage_t;

    stage_t st_d, st_q;
    dec_t   dec;

    logic [VEC_W-1:0] t_vec;
    logic [VEC_W-1:0] lane_sum;
    logic             unused_y_hi;

    // funnel: Y low word on top, X moved down one word
    assign t_vec       = {y_in[LANE_W-1:0], x_in[VEC_W-1:LANE_W]};
    assign unused_y_hi = ^y_in[VEC_W-1:LANE_W];

    s0_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        s0_lane #(
            .LANE_W (LANE_W),
            .ROT_A  (ROT_A),
            .ROT_B  (ROT_B),
            .SHR_C  (SHR_C)
        ) u_lane (
            .t_i   (t_vec[e*LANE_W +: LANE_W]),
            .x_i   (x_in[e*LANE_W +: LANE_W]),
            .sum_o (lane_sum[e*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        st_d.wr_en = valid_in && !dec.undef;
        st_d.undef = valid_in && dec.undef;
        if (valid_in) begin
            st_d.dst    = dec.dst;
            st_d.src    = dec.src;
            st_d.result = dec.undef ? '0 : lane_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.valid;
    assign wr_en     = st_q.wr_en;
    assign undef     = st_q.undef;
    assign dst_idx   = st_q.dst;
    assign src_idx   = st_q.src;
    assign result    = st_q.result;
endmodule

// File: rtl/s0_checker.sv
module s0_checker
    import sigma0_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [INSN_W-1:0] insn,
    input logic              valid_out,
    input logic              wr_en,
    input logic              undef,
    input logic [QIDX_W-1:0] dst_idx,
    input logic [QIDX_W-1:0] src_idx,
    input logic [VEC_W-1:0]  result
);
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    p_valid_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    p_size_undef_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && insn[19:18] != 2'b10) |=> undef);
    p_odd_undef_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (insn[12] || insn[0])) |=> undef);
    p_index_r8: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (dst_idx == {$past(insn[22]), $past(insn[15:13])} &&
                      src_idx == {$past(insn[5]), $past(insn[3:1])}));
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && undef));
    p_flags_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en || undef) |-> valid_out);
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        undef |-> (result == '0));
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!valid_out && !wr_en && !undef && result == '0));
endmodule

bind sched_sigma0_unit s0_checker #(.VEC_W(LANE_W*LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .insn      (insn),
    .valid_out (valid_out),
    .wr_en     (wr_en),
    .undef     (undef),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .result    (result)
);

// File: tb/sched_sigma0_unit_test.sv
`timescale 1ns/1ps
module sched_sigma0_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] x_in = '0;
    logic [127:0] y_in = '0;
    logic         valid_out, wr_en, undef;
    logic [3:0]   dst_idx, src_idx;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sched_sigma0_unit uut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .insn(insn),
        .x_in(x_in), .y_in(y_in), .valid_out(valid_out), .wr_en(wr_en),
        .undef(undef), .dst_idx(dst_idx), .src_idx(src_idx), .result(result)
    );

    localparam int NV = 6;
    localparam logic [3:0] QD_TAB [NV] = '{4'd0, 4'd3, 4'd8, 4'd15, 4'd9, 4'd6};
    localparam logic [3:0] QM_TAB [NV] = '{4'd1, 4'd12, 4'd7, 4'd0, 4'd9, 4'd14};
    localparam logic [127:0] X_TAB [NV] = '{
        128'h0123456789abcdef_fedcba9876543210,
        128'hffffffff_ffffffff_ffffffff_ffffffff,
        128'h00000000_00000000_00000000_00000000,
        128'h80000000_00000001_7fffffff_deadbeef,
        128'h13579bdf_2468ace0_0f0f0f0f_f0f0f0f0,
        128'hcafef00d_baadc0de_55aa55aa_a5a5a5a5};
    localparam logic [127:0] Y_TAB [NV] = '{
        128'h11111111_22222222_33333333_44444444,
        128'hffffffff_ffffffff_ffffffff_ffffffff,
        128'h00000000_00000000_00000000_80000000,
        128'h0badf00d_12345678_9abcdef0_00000001,
        128'h00000000_00000000_00000000_ffffffff,
        128'h01020304_05060708_090a0b0c_0d0e0f10};

    function automatic logic [31:0] mk(input logic [3:0] qd, input logic [3:0] qm,
                                       input logic [1:0] size);
        logic [4:0] rd, rm;
        rd = {qd, 1'b0};
        rm = {qm, 1'b0};
        return {9'b111100111, rd[4], 2'b11, size, 2'b10, rd[3:0],
                6'b001111, rm[4], 1'b0, rm[3:0]};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] r;
        logic [31:0] t, s;
        for (int e = 0; e < 4; e++) begin
            t = (e == 3) ? y[31:0] : x[32*(e+1) +: 32];
            s = {t[6:0], t[31:7]} ^ {t[17:0], t[31:18]} ^ {3'b000, t[31:3]};
            r[32*e +: 32] = s + x[32*e +: 32];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] x, input logic [127:0] y);
        @(negedge clk);
        valid_in = 1'b1; insn = w; x_in = x; y_in = y;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic expect_good(input logic [127:0] exp, input logic [3:0] qd,
                               input logic [3:0] qm, input string tag);
        chk(result == exp, {tag, " R1 R2 R3 result"}, result, exp);
        chk(valid_out && wr_en && !undef, {tag, " R4 R9 flags"},
            {valid_out, wr_en, undef}, 3'b110);
        chk(dst_idx == qd && src_idx == qm, {tag, " R8 indices"},
            {dst_idx, src_idx}, {qd, qm});
    endtask

    task automatic expect_bad(input string tag);
        chk(valid_out && undef && !wr_en, {tag, " flags"},
            {valid_out, wr_en, undef}, 3'b101);
        chk(result == '0, {tag, " R9 zero result"}, result, 128'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] w_abc_lo, w_abc_hi, e;
        repeat (3) @(negedge clk);
        chk(!valid_out && !wr_en && !undef && result == '0, "R10 reset state",
            {valid_out, wr_en, undef, result}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(mk(QD_TAB[i], QM_TAB[i], 2'b10), X_TAB[i], Y_TAB[i]);
            expect_good(model(X_TAB[i], Y_TAB[i]), QD_TAB[i], QM_TAB[i], "table");
        end

        // R4: single pulse, flags drop with it
        @(negedge clk);
        chk(!valid_out && !wr_en && !undef, "R4 single pulse",
            {valid_out, wr_en, undef}, '0);

        // R1 R2: Y word 0 = 1 lands in lane 3 -> 0x02004000
        issue(mk(4'd2, 4'd5, 2'b10), 128'h0, 128'h1);
        expect_good({32'h02004000, 96'h0}, 4'd2, 4'd5, "lane3 R1");

        // R3: lane 0 wraps, lane 1 must not see a carry
        issue(mk(4'd1, 4'd1, 2'b10), {64'h0, 32'h8, 32'hffffffff}, 128'h0);
        expect_good({64'h0, 32'h8, 32'h10020000}, 4'd1, 4'd1, "carry R3");

        // message schedule words of the padded "abc" block
        w_abc_lo = {32'h0, 32'h0, 32'h0, 32'h61626380};
        w_abc_hi = {32'h00000018, 32'h0, 32'h0, 32'h0};
        issue(mk(4'd4, 4'd5, 2'b10), w_abc_lo, 128'h0);
        expect_good({96'h0, 32'h61626380}, 4'd4, 4'd5, "abc W0-3 R2");
        e = model(w_abc_hi, w_abc_lo);
        issue(mk(4'd7, 4'd4, 2'b10), w_abc_hi, w_abc_lo);
        expect_good(e, 4'd7, 4'd4, "abc W12-15 R2");

        // R5: bad size fields with live operands
        issue(mk(4'd3, 4'd3, 2'b00), X_TAB[0], Y_TAB[0]);
        expect_bad("R5 size 00");
        issue(mk(4'd3, 4'd3, 2'b11), X_TAB[3], Y_TAB[3]);
        expect_bad("R5 size 11");
        // R6: odd register fields
        issue(mk(4'd3, 4'd3, 2'b10) | 32'h0000_1000, X_TAB[0], Y_TAB[0]);
        expect_bad("R6 odd Vd");
        issue(mk(4'd3, 4'd3, 2'b10) | 32'h0000_0001, X_TAB[0], Y_TAB[0]);
        expect_bad("R6 odd Vm");
        // R7: fixed bits broken
        issue(mk(4'd3, 4'd3, 2'b10) ^ 32'h8000_0000, X_TAB[5], Y_TAB[5]);
        expect_bad("R7 bit31");
        issue(mk(4'd3, 4'd3, 2'b10) | 32'h0000_0010, X_TAB[5], Y_TAB[5]);
        expect_bad("R7 bit4");
        issue(mk(4'd3, 4'd3, 2'b10) ^ 32'h0000_0040, X_TAB[5], Y_TAB[5]);
        expect_bad("R7 bit6");
        // good request right after a rejected one
        issue(mk(4'd11, 4'd13, 2'b10), X_TAB[5], Y_TAB[5]);
        expect_good(model(X_TAB[5], Y_TAB[5]), 4'd11, 4'd13, "after undef R9");

        // R10: reset together with a request
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b1; insn = mk(4'd2, 4'd2, 2'b10);
        x_in = X_TAB[0]; y_in = Y_TAB[0];
        @(negedge clk);
        chk(!valid_out && !wr_en && !undef && result == '0, "R10 reset over request",
            {valid_out, wr_en, undef, result}, '0);
        rst = 1'b0; valid_in = 1'b0;
        @(negedge clk);
        chk(!valid_out, "R10 R4 idle after reset", {127'h0, valid_out}, 128'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule